// File: doc/BRIEF.md
# Asynchronous Character Retiming Buffer

This block sits behind a 1200-baud FSK demodulator and lets a slow host without a serial receiver collect each asynchronous character as eight individually strobed bits. It watches the raw demodulated stream and treats a mark-to-space (1 to 0) transition as the leading edge of a start bit. From that edge it times the centres of the eight data bits and shifts them into an internal register, least significant bit first.

When the last data bit has been captured, the level of the host strobe decides what happens next. A low strobe starts a handshake: the interrupt request is pulled low and the first stored bit appears on the serial output. Each strobe pulse then steps the output through the stored bits, and the raw stream is reconnected after the eighth pulse. A strobe held high means the host does not want retiming: the character is dropped, no interrupt is raised, and the serial output simply follows the raw data. An enable from the mode controller turns the whole function off and leaves the output in passthrough.

The control is a five-state machine. IDLE waits for a start edge (IDLE to START on a synchronized falling edge of the raw data while enabled). START waits 1.5 bit periods and takes bit 0 (START to DATA). DATA takes one sample per bit period and leaves after the eighth sample (DATA to DECIDE). DECIDE reads the strobe for one cycle (DECIDE to HANDOUT when it is low, DECIDE to IDLE when it is high). HANDOUT serves the host and returns on the eighth strobe falling edge (HANDOUT to IDLE). A low enable forces a return to IDLE from any state.

Top module: `char_retimer`

## Requirements
- R1: After reset, irq_n is high and ser_out follows raw_in, delayed by the two synchronizer stages.
- R2: A 1 to 0 transition of the synchronized raw data in IDLE starts a character. Bit 0 is sampled 1.5 bit periods (CLKS_PER_BIT + CLKS_PER_BIT/2 clocks) after the edge, and each later bit one bit period after the previous one. The eight samples form the stored byte, LSB first.
- R3: If the synchronized strobe is low when the eighth bit has been captured, irq_n goes low and ser_out carries stored bit 0. Both hold until the strobe rises.
- R4: irq_n returns high on the first rising edge of the strobe and stays high for the rest of the handout.
- R5: On the falling edge of strobe pulse k (k = 1 to 7), ser_out presents stored bit k.
- R6: On the falling edge of the eighth strobe pulse, ser_out returns to the raw data and the block goes back to IDLE.
- R7: If the strobe is high when the eighth bit has been captured, irq_n stays high, the stored byte is dropped, and ser_out follows the raw data at all times.
- R8: During the handout, a falling edge on the raw data does not start a character. Start detection is re-armed once the handout is complete.
- R9: While enable is low, irq_n is high, ser_out follows the raw data, and any capture or handout in progress is abandoned.
- R10: An alternating mark/space preamble (start 0, then bits 1,0,1,0,1,0,1,0 in order of arrival) is handed out as the byte 0x55.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Retiming function enabled by mode control |
| raw_in | input | 1 | Raw demodulated serial data (1 = mark) |
| strobe_in | input | 1 | Host strobe; level at character end selects handshake or passthrough |
| ser_out | output | 1 | Raw data, or the stored bit during handout |
| irq_n | output | 1 | Active-low interrupt request to the host |

## Verification
On every cycle, the assertions check the following: the interrupt is only low during the handout, DECIDE leads to the handout with a low strobe and to IDLE with a high one, the interrupt clears on the strobe rise, the eighth strobe fall returns the block to IDLE, the handout never leaves for a capture state, and a low enable forces idle passthrough. Only the bench scenarios can show the data itself. For this, it sweeps all 256 byte values through bit-centre sampling and the serial handout, follows the passthrough waveform with the strobe held high and with the block disabled, replays the alternating preamble, and confirms that a start edge injected during a handout is ignored while the next character is still captured.

// File: rtl/cr_pkg.sv
package cr_pkg;
    typedef enum logic [2:0] {
        CR_IDLE,
        CR_START,
        CR_DATA,
        CR_DECIDE,
        CR_HAND
    } cr_state_e;
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cr_edge.sv
module cr_edge #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= INIT;
        else        d_q <= d;
    end

    assign rise = d & ~d_q;
    assign fall = ~d & d_q;
endmodule

// File: rtl/cr_bit_timer.sv
module cr_bit_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] last,
    output logic          hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == last);
endmodule

// File: rtl/char_retimer.sv
module char_retimer #(
    parameter int CLKS_PER_BIT = 2983,
    parameter int DATA_BITS    = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic raw_in,
    input  logic strobe_in,
    output logic ser_out,
    output logic irq_n
);
    import cr_pkg::*;

    localparam int FIRST_WAIT = CLKS_PER_BIT + CLKS_PER_BIT / 2;
    localparam int CW         = $clog2(FIRST_WAIT + 1);
    localparam int IW         = $clog2(DATA_BITS);
    localparam logic [CW-1:0] FIRST_LAST = CW'(FIRST_WAIT - 1);
    localparam logic [CW-1:0] BIT_LAST   = CW'(CLKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST   = IW'(DATA_BITS - 1);

    logic raw_s, strobe_s;
    logic raw_rise_unused, raw_fall;
    logic stb_rise, stb_fall;
    logic tmr_clear, tmr_hit;
    logic [CW-1:0] tmr_last;

    cr_state_e state, state_nx;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 irq_q;

    cr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_raw_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(raw_s)
    );
    cr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(strobe_in), .q(strobe_s)
    );
    cr_edge #(.INIT(1'b1)) u_raw_edge (
        .clk(clk), .rst_n(rst_n), .d(raw_s),
        .rise(raw_rise_unused), .fall(raw_fall)
    );
    cr_edge #(.INIT(1'b0)) u_stb_edge (
        .clk(clk), .rst_n(rst_n), .d(strobe_s),
        .rise(stb_rise), .fall(stb_fall)
    );

    assign tmr_last  = (state == CR_START) ? FIRST_LAST : BIT_LAST;
    assign tmr_clear = !((state == CR_START) || (state == CR_DATA)) || tmr_hit;

    cr_bit_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear),
        .last(tmr_last), .hit(tmr_hit)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            CR_IDLE:   if (raw_fall) state_nx = CR_START;
            CR_START:  if (tmr_hit) state_nx = CR_DATA;
            CR_DATA:   if (tmr_hit && idx == IDX_LAST) state_nx = CR_DECIDE;
            CR_DECIDE: state_nx = strobe_s ? CR_IDLE : CR_HAND;
            CR_HAND:   if (stb_fall && idx == IDX_LAST) state_nx = CR_IDLE;
            default:   state_nx = CR_IDLE;
        endcase
        if (!enable) state_nx = CR_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CR_IDLE;
        else        state <= state_nx;
    end

    // capture, handout index and interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            shreg <= '0;
            irq_q <= 1'b0;
        end else if (!enable) begin
            idx   <= '0;
            irq_q <= 1'b0;
        end else begin
            unique case (state)
                CR_IDLE: begin
                    idx   <= '0;
                    irq_q <= 1'b0;
                end
                CR_START: if (tmr_hit) begin
                    shreg <= {raw_s, shreg[DATA_BITS-1:1]};
                    idx   <= IW'(1);
                end
                CR_DATA: if (tmr_hit) begin
                    shreg <= {raw_s, shreg[DATA_BITS-1:1]};
                    idx   <= idx + 1'b1;
                end
                CR_DECIDE: begin
                    idx   <= '0;
                    irq_q <= !strobe_s;
                end
                CR_HAND: begin
                    if (stb_rise) irq_q <= 1'b0;
                    if (stb_fall) begin
                        shreg <= {1'b0, shreg[DATA_BITS-1:1]};
                        idx   <= idx + 1'b1;
                    end
                end
                default: idx <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        ser_out = (state == CR_HAND) ? shreg[0] : raw_s;
        irq_n   = !irq_q;
    end
endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
    parameter int IW        = 3,
    parameter int DATA_BITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              strobe_s,
    input logic              stb_rise,
    input logic              stb_fall,
    input cr_pkg::cr_state_e state,
    input logic [IW-1:0]     idx,
    input logic              irq_n
);
    import cr_pkg::*;

    a_r3_irq_only_in_handout: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> state == CR_HAND);

    a_r3_enter_handout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CR_DECIDE && !strobe_s && enable) |=> (!irq_n && state == CR_HAND));

    a_r7_strobe_high_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CR_DECIDE && strobe_s) |=> (irq_n && state == CR_IDLE));

    a_r4_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CR_HAND && stb_rise) |=> irq_n);

    a_r6_return_on_eighth: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CR_HAND && stb_fall && idx == IW'(DATA_BITS - 1)) |=> state == CR_IDLE);

    a_r8_no_capture_in_handout: assert property (@(posedge clk) disable iff (!rst_n)
        state == CR_HAND |=> (state == CR_HAND || state == CR_IDLE));

    a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (irq_n && state == CR_IDLE));
endmodule

bind char_retimer cr_checker #(.IW(IW), .DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe_s(strobe_s),
    .stb_rise(stb_rise), .stb_fall(stb_fall), .state(state),
    .idx(idx), .irq_n(irq_n)
);

// File: tb/sim_char_retimer.sv
`timescale 1ns/1ps
module sim_char_retimer;
    localparam int CPB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic raw_in = 1'b1;
    logic strobe_in = 1'b0;
    logic ser_out, irq_n;

    int tests = 0;
    int failed = 0;

    always #10 clk = ~clk;

    char_retimer #(.CLKS_PER_BIT(CPB), .DATA_BITS(8), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .raw_in(raw_in),
        .strobe_in(strobe_in), .ser_out(ser_out), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // frame: start 0, eight bits LSB first, stop 1
    task automatic send_char(input logic [7:0] v, input logic watch_pass, input string req);
        logic [9:0] frame;
        frame = {1'b1, v, 1'b0};
        for (int b = 0; b < 10; b++) begin
            raw_in = frame[b];
            wait_clk(CPB / 2);
            if (watch_pass) begin
                check({req, " passthrough ser_out"}, 8'(ser_out), 8'(frame[b]));
                check({req, " irq_n stays high"}, 8'(irq_n), 8'd1);
            end
            wait_clk(CPB - CPB / 2);
        end
    endtask

    task automatic handout(input logic [7:0] exp, input logic glitch, output logic [7:0] got);
        check("R3 irq_n low after capture", 8'(irq_n), 8'd0);
        wait_clk(20);
        check("R3 irq_n held low", 8'(irq_n), 8'd0);
        check("R3 first bit on ser_out", 8'(ser_out), 8'(exp[0]));
        got[0] = ser_out;
        for (int k = 0; k < 8; k++) begin
            strobe_in = 1'b1;
            wait_clk(4);
            check("R4 irq_n released by strobe", 8'(irq_n), 8'd1);
            strobe_in = 1'b0;
            wait_clk(4);
            if (k < 7) begin
                got[k+1] = ser_out;
                check("R5 next bit on strobe fall", 8'(ser_out), 8'(exp[k+1]));
            end else begin
                check("R6 raw data back after eighth pulse", 8'(ser_out), 8'(raw_in));
            end
            if (glitch && k == 0) begin
                raw_in = 1'b0;
                wait_clk(2 * CPB);
                check("R8 handout bit held during raw edge", 8'(ser_out), 8'(exp[1]));
                raw_in = 1'b1;
                wait_clk(4);
            end
        end
    endtask

    initial begin
        logic [7:0] got;
        wait_clk(3);
        check("R1 reset irq_n", 8'(irq_n), 8'd1);
        check("R1 reset ser_out", 8'(ser_out), 8'd1);
        rst_n = 1'b1;
        wait_clk(2);
        raw_in = 1'b1;
        wait_clk(CPB);

        // R2/R3/R5/R6: all byte values through the handshake
        for (int v = 0; v < 256; v++) begin
            send_char(8'(v), 1'b0, "R2");
            handout(8'(v), 1'b0, got);
            check("R2 assembled byte", got, 8'(v));
            wait_clk(4);
        end

        // R10: alternating preamble
        send_char(8'h55, 1'b0, "R10");
        handout(8'h55, 1'b0, got);
        check("R10 preamble byte", got, 8'h55);
        wait_clk(4);

        // R7: strobe held high, passthrough and no interrupt
        strobe_in = 1'b1;
        wait_clk(4);
        send_char(8'hA3, 1'b1, "R7");
        send_char(8'h3C, 1'b1, "R7");
        wait_clk(CPB);
        check("R7 no irq after character", 8'(irq_n), 8'd1);
        strobe_in = 1'b0;
        wait_clk(4);

        // R8: raw edge during handout is ignored, block re-arms
        send_char(8'h96, 1'b0, "R8");
        handout(8'h96, 1'b1, got);
        check("R8 byte survives raw edge", got, 8'h96);
        wait_clk(12 * CPB);
        check("R8 no character from handout edge", 8'(irq_n), 8'd1);
        send_char(8'h5A, 1'b0, "R8");
        handout(8'h5A, 1'b0, got);
        check("R8 rearmed capture", got, 8'h5A);
        wait_clk(4);

        // R9: disabled block passes raw data
        enable = 1'b0;
        wait_clk(2);
        send_char(8'hC1, 1'b1, "R9");
        wait_clk(CPB);
        check("R9 no irq while disabled", 8'(irq_n), 8'd1);
        // R9: disable during capture abandons it
        enable = 1'b1;
        wait_clk(2);
        raw_in = 1'b0;
        wait_clk(3 * CPB);
        enable = 1'b0;
        raw_in = 1'b1;
        wait_clk(8 * CPB);
        check("R9 abandoned capture raises no irq", 8'(irq_n), 8'd1);
        check("R9 ser_out follows raw", 8'(ser_out), 8'd1);
        enable = 1'b1;
        wait_clk(4);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule